// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block turns the bank of comparator outputs of an N-bit parallel analog-to-digital converter into an N-bit binary sample. The comparators give a thermometer vector of 2^N − 1 bits. Vector bit i is 1 when the analog level lies above reference level i+1, and each level sits one LSB above the one below it. A level of zero needs no line of its own, because it is an all-zero vector.

A capture strobe `smp_en` admits one vector into a single sampling register. No other logic reads the raw comparator lines, so a metastable comparator is resolved in exactly one place. The next stage finds the top of the run of ones with a three-bit window. A lone zero below the top, or a lone one above it, therefore cannot move the result by a large amount. That stage emits the position as a Gray code. The output stage decodes it to binary and raises `smp_valid` together with `smp_bubble`, which marks a vector that was not a clean thermometer code.

The input side is a plain strobe and the output side is a valid-only stream. There is no ready signal, because comparators cannot be stalled. The downstream logic must take every result in the single cycle in which `smp_valid` is high. Between results, the code and the flag hold their last values.

Top module: `therm_flash_enc`

## Requirements
- R1: While reset is active, and until the first result, `smp_valid`, `smp_code` and `smp_bubble` are all 0.
- R2: An enable sampled high at clock edge E gives `smp_valid` high after edge E+2, for exactly one cycle per sampled enable. With no enable, `smp_valid` stays low.
- R3: A clean thermometer vector has bits 0 to m−1 at 1 and all other bits at 0. Such a vector gives `smp_code` = m for every m from 1 to 2^N − 2.
- R4: The all-zero vector gives code 0. The all-ones vector gives code 2^N − 1. Neither raises `smp_bubble`.
- R5: Number the positions k = 1 to 2^N − 1, where position k is vector bit k−1. Treat the position below the vector as 1 and the position above it as 0. The code is the highest k whose own bit and the bit below it are both 1 and whose bit above is 0. If no k qualifies, the code is 0. Example at N=4: vector 0x0017 gives code 3.
- R6: A lone 1 above a 0 does not raise the code. Example at N=4: vector 0x4003 gives code 2.
- R7: `smp_bubble` is high with a result exactly when its vector had some bit at 1 directly above a bit at 0.
- R8: Changes on `smp_therm` while `smp_en` is low leave all outputs unchanged.
- R9: Enables on consecutive cycles give results on consecutive cycles, in the order the vectors were captured.
- R10: While `smp_valid` is low, `smp_code` and `smp_bubble` hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Capture strobe for the comparator vector |
| smp_therm | input | 2^N−1 | Raw comparator outputs; bit i is level i+1 |
| smp_valid | output | 1 | One-cycle marker of a new result |
| smp_code | output | N | Binary code of the result |
| smp_bubble | output | 1 | The result came from a vector that was not a clean thermometer code |

## Verification
The assertions assume three things. The vector is stable at the edge where `smp_en` is sampled, the enable is a synchronous level, and the sink never needs to stall, since there is no ready signal to honour. They relate each result to the vector seen three edges earlier. They check code equal to the count of ones for clean vectors, bubble equal to "not a clean thermometer", and outputs held between results. The stimulus drives vector and enable only on the falling edge and samples outputs there too, so every captured vector is settled and every result is read one half-cycle after it appears.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

  parameter int unsigned TE_DEF_BITS = 4;

  // Gray to binary on a wide word; callers slice the low bits they need.
  function automatic logic [31:0] te_gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic [31:0] te_bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/te_sample.sv
module te_sample #(
  parameter int unsigned M = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [M-1:0] therm_i,
  output logic [M-1:0] samp_o,
  output logic         vld_o
);
  // Sole reader of the raw comparator lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) samp_o <= therm_i;
    end
  end
endmodule

// File: rtl/te_locate.sv
module te_locate
  import therm_enc_pkg::*;
#(
  parameter int unsigned N = TE_DEF_BITS,
  localparam int unsigned M = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [M-1:0] samp_i,
  output logic [N-1:0] gray_o,
  output logic         bub_o,
  output logic         vld_o
);
  logic [M+1:0] ext;
  logic [M:1]   hit;
  logic [N-1:0] idx;
  logic         dirty;
  logic [31:0]  gw;

  // Pad with an implied 1 below and an implied 0 above the vector.
  assign ext = {1'b0, samp_i, 1'b1};

  genvar k;
  generate
    for (k = 1; k <= M; k++) begin : g_win
      assign hit[k] = ext[k-1] & ext[k] & ~ext[k+1];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int p = 1; p <= M; p++) begin
      if (hit[p]) idx = N'(p);
    end
  end

  always_comb begin
    dirty = 1'b0;
    for (int p = 1; p < M; p++) begin
      if (samp_i[p] && !samp_i[p-1]) dirty = 1'b1;
    end
  end

  assign gw = te_bin2gray(32'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_o <= '0;
      bub_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        gray_o <= gw[N-1:0];
        bub_o  <= dirty;
      end
    end
  end
endmodule

// File: rtl/te_decode.sv
module te_decode
  import therm_enc_pkg::*;
#(
  parameter int unsigned N = TE_DEF_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [N-1:0] gray_i,
  input  logic         bub_i,
  output logic [N-1:0] code_o,
  output logic         bub_o,
  output logic         vld_o
);
  logic [31:0] bw;
  assign bw = te_gray2bin(32'(gray_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      bub_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        code_o <= bw[N-1:0];
        bub_o  <= bub_i;
      end
    end
  end
endmodule

// File: rtl/therm_flash_enc.sv
module therm_flash_enc
  import therm_enc_pkg::*;
#(
  parameter int unsigned N = TE_DEF_BITS,
  localparam int unsigned M = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [M-1:0] smp_therm,
  output logic         smp_valid,
  output logic [N-1:0] smp_code,
  output logic         smp_bubble
);
  logic [M-1:0] s1_vec;
  logic         s1_vld;
  logic [N-1:0] s2_gray;
  logic         s2_bub;
  logic         s2_vld;

  te_sample #(.M(M)) u_sample (
    .clk(clk), .rst_n(rst_n), .en_i(smp_en), .therm_i(smp_therm),
    .samp_o(s1_vec), .vld_o(s1_vld)
  );

  te_locate #(.N(N)) u_locate (
    .clk(clk), .rst_n(rst_n), .vld_i(s1_vld), .samp_i(s1_vec),
    .gray_o(s2_gray), .bub_o(s2_bub), .vld_o(s2_vld)
  );

  te_decode #(.N(N)) u_decode (
    .clk(clk), .rst_n(rst_n), .vld_i(s2_vld), .gray_i(s2_gray), .bub_i(s2_bub),
    .code_o(smp_code), .bub_o(smp_bubble), .vld_o(smp_valid)
  );
endmodule

// File: rtl/therm_flash_enc_chk.sv
module therm_flash_enc_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned M = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_en,
  input logic [M-1:0] smp_therm,
  input logic         smp_valid,
  input logic [N-1:0] smp_code,
  input logic         smp_bubble
);
  // A vector is a clean thermometer code when v+1 is a power of two.
  function automatic logic not_clean(input logic [M-1:0] v);
    logic [M-1:0] nx;
    nx = v + 1'b1;
    return (nx & v) != '0;
  endfunction

  AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> ##3 smp_valid); // R2
  AST_LATENCY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(smp_en, 3)); // R2
  AST_CLEAN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_bubble) |-> (smp_code == N'($countones($past(smp_therm, 3))))); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(smp_therm, 3) == '0) |-> (smp_code == '0)); // R4
  AST_BUBBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_bubble == not_clean($past(smp_therm, 3)))); // R7
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(smp_code) && $stable(smp_bubble))); // R10
endmodule

bind therm_flash_enc therm_flash_enc_chk #(.N(N), .M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_therm(smp_therm),
  .smp_valid(smp_valid), .smp_code(smp_code), .smp_bubble(smp_bubble)
);

// File: tb/test_therm_flash_enc.sv
module test_therm_flash_enc;
  localparam int unsigned N = 4;
  localparam int unsigned M = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_en = 1'b0;
  logic [M-1:0] smp_therm = '0;
  logic         smp_valid;
  logic [N-1:0] smp_code;
  logic         smp_bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  therm_flash_enc #(.N(N)) i_therm_flash_enc (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_therm(smp_therm),
    .smp_valid(smp_valid), .smp_code(smp_code), .smp_bubble(smp_bubble)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one vector, verify the valid timing and the result.
  task automatic convert(input logic [M-1:0] v, input int ecode, input int ebub, input string req);
    @(negedge clk); smp_therm = v; smp_en = 1'b1;
    @(negedge clk); smp_en = 1'b0;
    chk("R2 valid early", int'(smp_valid), 0);
    @(negedge clk);
    chk("R2 valid early", int'(smp_valid), 0);
    @(negedge clk);
    chk("R2 valid on time", int'(smp_valid), 1);
    chk(req, int'(smp_code), ecode);
    chk({req, " R7 bubble"}, int'(smp_bubble), ebub);
    @(negedge clk);
    chk("R2 single pulse", int'(smp_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(smp_valid), 0);
    chk("R1 code", int'(smp_code), 0);
    chk("R1 bubble", int'(smp_bubble), 0);
  endtask

  task automatic t_clean();
    for (int m = 1; m < M; m++) begin
      logic [M:0] t;
      t = (M+1)'((1 << m) - 1);
      convert(t[M-1:0], m, 0, "R3 clean level");
    end
  endtask

  task automatic t_ends();
    convert('0, 0, 0, "R4 all zero");
    convert('1, M, 0, "R4 all one");
  endtask

  task automatic t_bubbles();
    convert(15'h0017, 3, 1, "R5 zero below top");
    convert(15'h007E, 7, 1, "R5 bottom zero");
    convert(15'h01DF, 9, 1, "R5 mid zero");
    convert(15'h4003, 2, 1, "R6 stray one");
  endtask

  task automatic t_ignore();
    convert(15'h003F, 6, 0, "R8 setup");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); smp_therm = (i % 2 == 0) ? '1 : 15'h0101;
      chk("R8 no valid", int'(smp_valid), 0);
      chk("R10 code held", int'(smp_code), 6);
      chk("R10 bubble held", int'(smp_bubble), 0);
    end
  endtask

  task automatic t_stream();
    @(negedge clk); smp_therm = 15'h0001; smp_en = 1'b1;
    @(negedge clk); smp_therm = 15'h0005;
    @(negedge clk); smp_therm = 15'h07FF;
    @(negedge clk); smp_en = 1'b0;
    chk("R9 first", int'(smp_valid), 1);
    chk("R9 first code", int'(smp_code), 1);
    chk("R9 first bubble", int'(smp_bubble), 0);
    @(negedge clk);
    chk("R9 second", int'(smp_valid), 1);
    chk("R9 second code", int'(smp_code), 1);
    chk("R9 second bubble", int'(smp_bubble), 1);
    @(negedge clk);
    chk("R9 third", int'(smp_valid), 1);
    chk("R9 third code", int'(smp_code), 11);
    chk("R9 third bubble", int'(smp_bubble), 0);
    @(negedge clk);
    chk("R2 stream ends", int'(smp_valid), 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_ends();
    t_bubbles();
    t_ignore();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule